// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Status and Mask

This block combines the transmit-ready and receive-ready flags of a set of serial channels (two by default) into one status word and drives a single active-low interrupt request. Each channel has its own 4-bit group in the status word. The transmit-ready flag sits in the lowest bit of the group and the receive-ready flag in the next bit up. The two upper bits of each group are reserved for sources that this block does not handle, and they always read as zero.

A small register port exposes a single decoded offset. A write to that offset loads the enable mask, and a read of the same offset returns the status. The status has no storage of its own. It is the live level of the channel flags. An interrupt is therefore cleared at its source: once a channel's flag drops, its status bit drops with it, and the request goes inactive unless another enabled source is still pending. The request line is registered so that it cannot glitch, which makes it safe for a receiver that detects a falling edge.

The register port is a plain synchronous strobe interface. It has no valid/ready handshake and never applies back-pressure: a read strobe is always answered by a read-valid pulse one cycle later, and a write always takes effect at the edge that samples it.

Top module: `uart_irq_hub`

## Requirements
- R1: A read strobe at offset 5 returns, one cycle later with `bus_rvalid` high, the status sampled at the strobe's clock edge. Channel n transmit-ready appears at bit 4n, channel n receive-ready at bit 4n+1, and bits 4n+2 and 4n+3 read as 0.
- R2: A write strobe at offset 5 loads `bus_wdata` into the mask at that clock edge. Mask bit k enables status bit k.
- R3: After reset the mask is 0, `irq_n` is 1 and `bus_rvalid` is 0. With a zero mask, `irq_n` stays 1 whatever the sources do.
- R4: `irq_n` is 0 exactly when the status ANDed with the mask is nonzero. It reflects the sources and the mask sampled at the preceding clock edge, including a mask written at that edge.
- R5: Status is not latched. When an enabled source drops, `irq_n` returns to 1 one edge later unless another enabled source is still active.
- R6: Writes to any offset other than 5 leave the mask unchanged. Reads at any other offset produce no `bus_rvalid` pulse.
- R7: Mask bits at reserved positions (4n+2, 4n+3) never cause a request.
- R8: Reading the status does not clear it. Repeated reads return the same value, and the request stays active for as long as the source stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_rdy | input | NUM_CH | Per-channel transmit-ready level |
| rx_rdy | input | NUM_CH | Per-channel receive-ready level |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 4*NUM_CH | Write data (mask) |
| bus_rdata | output | 4*NUM_CH | Read data (status) |
| bus_rvalid | output | 1 | Read data valid, one cycle after a decoded read |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The embedded properties watch four things on every cycle: that a decoded read is answered with a pulse one cycle later, that a non-decoded read gets no answer, that the mask holds its value when no decoded write occurs, and that reserved bits never show up in read data. They also check that the request is released whenever all sources are idle or the mask is empty. The bench scenarios cover what needs an independent model of the mask: the exact bit position of each channel source, which is walked source by source, and the level behaviour when a source drops. The scenarios also show that reserved mask bits have no effect and that reads do not clear the status.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  // Width of one channel's group inside the status word.
  localparam int unsigned NIB_W  = 4;
  // Position of each source inside a group; software decodes these.
  localparam int unsigned TX_OFS = 0;
  localparam int unsigned RX_OFS = 1;
  // Upper bound on channels for the live-bit helper below.
  localparam int unsigned MAX_CH = 8;

  // Bits of the status word that carry a real source.
  function automatic logic [31:0] live_bits(input int unsigned nch);
    logic [31:0] v;
    v = '0;
    for (int unsigned c = 0; c < MAX_CH; c++) begin
      if (c < nch) begin
        v[c*NIB_W + TX_OFS] = 1'b1;
        v[c*NIB_W + RX_OFS] = 1'b1;
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/uirq_collect.sv
module uirq_collect
  import uirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH-1:0]       tx_rdy,
  input  logic [NUM_CH-1:0]       rx_rdy,
  output logic [NUM_CH*NIB_W-1:0] status
);

  // One group per channel; unused slots tie to zero.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar k = 0; k < NIB_W; k++) begin : g_bit
      if (k == TX_OFS) begin : g_tx
        assign status[c*NIB_W + k] = tx_rdy[c];
      end else if (k == RX_OFS) begin : g_rx
        assign status[c*NIB_W + k] = rx_rdy[c];
      end else begin : g_rsv
        assign status[c*NIB_W + k] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/uirq_regport.sv
module uirq_regport #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned HIT_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [STAT_W-1:0] bus_wdata,
  input  logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask_q,
  output logic [STAT_W-1:0] mask_nxt,
  output logic [STAT_W-1:0] bus_rdata,
  output logic              bus_rvalid
);

  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(HIT_ADDR);

  logic hit;
  assign hit      = (bus_addr == HIT);
  assign mask_nxt = (bus_wr && hit) ? bus_wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      mask_q     <= mask_nxt;
      bus_rvalid <= bus_rd && hit;
      if (bus_rd && hit) begin
        bus_rdata <= status;
      end
    end
  end

  // R1: a decoded read is always answered on the next cycle
  assert_rd_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit) |=> bus_rvalid);

  // R6: any other cycle yields no read-valid pulse
  assert_no_stray_rvalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && hit) |=> !bus_rvalid);

  // R6: the mask only moves on a decoded write
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit) |=> $stable(mask_q));

endmodule

// File: rtl/uirq_irq_out.sv
module uirq_irq_out #(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask_nxt,
  output logic              irq_n
);

  // Registered so the line cannot glitch for an edge-sensing receiver.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n <= 1'b1;
    end else begin
      irq_n <= ~|(status & mask_nxt);
    end
  end

  // R5: with no source active the request is released next edge
  assert_quiet_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> irq_n);

endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
  import uirq_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned ISR_ADDR = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       tx_rdy,
  input  logic [NUM_CH-1:0]       rx_rdy,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [NUM_CH*NIB_W-1:0] bus_wdata,
  output logic [NUM_CH*NIB_W-1:0] bus_rdata,
  output logic                    bus_rvalid,
  output logic                    irq_n
);

  localparam int unsigned       STAT_W = NUM_CH * NIB_W;
  localparam logic [31:0]       LIVE32 = live_bits(NUM_CH);
  localparam logic [STAT_W-1:0] LIVE   = LIVE32[STAT_W-1:0];
  localparam logic [ADDR_W-1:0] HIT    = ADDR_W'(ISR_ADDR);

  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] mask_nxt;

  uirq_collect #(.NUM_CH(NUM_CH)) collect_i (
    .tx_rdy (tx_rdy),
    .rx_rdy (rx_rdy),
    .status (status)
  );

  uirq_regport #(
    .ADDR_W   (ADDR_W),
    .STAT_W   (STAT_W),
    .HIT_ADDR (ISR_ADDR)
  ) regport_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .status     (status),
    .mask_q     (mask_q),
    .mask_nxt   (mask_nxt),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  uirq_irq_out #(.STAT_W(STAT_W)) irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (status),
    .mask_nxt (mask_nxt),
    .irq_n    (irq_n)
  );

  // R1: reserved positions never appear in returned status
  assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> ((bus_rdata & ~LIVE) == '0));

  // R3: an empty mask that is not being written keeps the line high
  assert_mask_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q == '0) && !(bus_wr && (bus_addr == HIT))) |=> irq_n);

  // R5: idle channels release the request
  assert_idle_inputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_rdy == '0) && (rx_rdy == '0)) |=> irq_n);

endmodule

// File: tb/uart_irq_hub_tb_top.sv
`timescale 1ns/1ps
module uart_irq_hub_tb_top;

  localparam int NCH = 2;
  localparam int SW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] tx_rdy = '0;
  logic [NCH-1:0] rx_rdy = '0;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [SW-1:0] bus_wdata = '0;
  logic [SW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic          irq_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [SW-1:0] mask_model = '0;
  logic [SW-1:0] exp_q[$];

  always #4 clk = ~clk;

  uart_irq_hub dut_i (
    .clk(clk), .rst_n(rst_n), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_n(irq_n)
  );

  function automatic logic [SW-1:0] exp_stat(logic [NCH-1:0] t, logic [NCH-1:0] r);
    logic [SW-1:0] s;
    s = '0;
    for (int c = 0; c < NCH; c++) begin
      s[4*c]     = t[c];
      s[4*c + 1] = r[c];
    end
    return s;
  endfunction

  task automatic check(bit ok, string req, string what, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_irq(string req);
    logic e;
    e = ~|(exp_stat(tx_rdy, rx_rdy) & mask_model);
    check(irq_n === e, req, "irq_n", {7'd0, irq_n}, {7'd0, e});
  endtask

  task automatic drive_src(logic [NCH-1:0] t, logic [NCH-1:0] r);
    tx_rdy = t;
    rx_rdy = r;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [SW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (a == 4'd5) mask_model = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a);
    bus_addr = a; bus_rd = 1'b1;
    if (a == 4'd5) exp_q.push_back(exp_stat(tx_rdy, rx_rdy));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: pops the scoreboard when read data appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected rvalid", bus_rdata, '0);
      end else begin
        logic [SW-1:0] e;
        e = exp_q.pop_front();
        check(bus_rdata === e, "R1", "read status", bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq_n === 1'b1, "R3", "irq_n in reset", {7'd0, irq_n}, 8'd1);
    check(bus_rvalid === 1'b0, "R3", "rvalid in reset", {7'd0, bus_rvalid}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reset mask blocks everything
    drive_src(2'b11, 2'b11);
    check(irq_n === 1'b1, "R3", "zero mask blocks", {7'd0, irq_n}, 8'd1);
    rd(4'd5);                                  // R1: expects 0x33

    // R2/R4: enable tx of channel 0
    wr(4'd5, 8'h01);
    chk_irq("R2");
    // R5: drop tx0, request releases
    drive_src(2'b10, 2'b11);
    chk_irq("R5");
    check(irq_n === 1'b1, "R5", "release after drop", {7'd0, irq_n}, 8'd1);

    // R2: rx of channel 1 at bit 5
    wr(4'd5, 8'h20);
    check(irq_n === 1'b0, "R2", "rx1 enabled", {7'd0, irq_n}, 8'd0);
    // R8: reads do not clear
    rd(4'd5);
    rd(4'd5);
    check(irq_n === 1'b0, "R8", "request survives reads", {7'd0, irq_n}, 8'd0);

    // R5: drop rx1
    drive_src(2'b10, 2'b01);
    chk_irq("R5");
    rd(4'd5);

    // R6: write to another offset leaves mask alone; read there is silent
    wr(4'd4, 8'hFF);
    drive_src(2'b11, 2'b01);
    chk_irq("R6");
    check(irq_n === 1'b1, "R6", "mask unchanged", {7'd0, irq_n}, 8'd1);
    rd(4'd4);
    check(bus_rvalid === 1'b0, "R6", "no rvalid off-offset", {7'd0, bus_rvalid}, 8'd0);

    // R7: reserved mask bits do nothing
    wr(4'd5, 8'hCC);
    drive_src(2'b11, 2'b11);
    check(irq_n === 1'b1, "R7", "reserved mask bits", {7'd0, irq_n}, 8'd1);
    rd(4'd5);

    // R4: walk each source against its own and the other mask bits
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 2; k++) begin
        logic [NCH-1:0] t, r;
        logic [SW-1:0] one;
        t = '0; r = '0;
        if (k == 0) t[c] = 1'b1; else r[c] = 1'b1;
        one = '0; one[4*c + k] = 1'b1;
        drive_src(t, r);
        wr(4'd5, one);
        check(irq_n === 1'b0, "R4", "own bit enabled", {7'd0, irq_n}, 8'd0);
        rd(4'd5);
        wr(4'd5, ~one & 8'h33);
        check(irq_n === 1'b1, "R4", "other bits only", {7'd0, irq_n}, 8'd1);
      end
    end

    // R3: clearing mask silences all sources
    drive_src(2'b11, 2'b11);
    wr(4'd5, 8'h00);
    chk_irq("R3");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R1", "all reads answered", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule